// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block models a single-port synchronous SRAM whose operations are split across two clock edges. On the first edge the address, direction and lane enables are latched. During the following cycle the data phase runs: either the addressed word flows straight from the array onto the read-data port, or the write-data port is captured into the selected byte lanes at the closing edge. Because each operation's data phase sits exactly one cycle behind its command, reads and writes can alternate every cycle with no idle bus cycle between them.

A load command carries a full address. An advance command steps an internal two-bit beat counter, which gives four words from one starting address, in either linear or interleaved order. An active-low clock enable freezes the whole block. Three chip-select inputs qualify every load. Output enable is the one asynchronous control. The data pins are modelled as separate input and output buses plus a drive flag: when the flag is low the pins float.

Top module: `zbt_sram_core`

## Requirements
- R1: A read command loaded at edge k puts the addressed word on `dataOut`, with `dataDrive` high, for the whole cycle after edge k. Read and write commands may follow each other on consecutive edges.
- R2: A write command loaded at edge k stores `dataIn` at edge k+1. A read of the same address loaded at edge k+1 returns the new word.
- R3: While `outEnN` is high, `dataDrive` is low at once, with no clock edge needed. Driving resumes when `outEnN` returns low.
- R4: While `clkEnN` is high, every input is ignored, no write is committed and all state holds, including a read word that is already being driven.
- R5: A load (`loadN`=0) starts an operation only when `csAN`=0, `csB`=1 and `csCN`=0. Any other combination deselects the block: `dataDrive` is low in the next cycle and nothing is written.
- R6: `dataDrive` stays low during the data phase of every write.
- R7: When `orderLinear`=1 at load, each advance (`loadN`=1) gives address bits [1:0] = (start + beat) mod 4. The upper address bits stay fixed.
- R8: When `orderLinear`=0 at load, address bits [1:0] = start[1:0] XOR beat. On advances, `addr` and `orderLinear` are ignored.
- R9: `laneWrN[i]`=0 at the command edge lets a write update bits [9i+8:9i]. A lane whose bit is 1 keeps its old contents.
- R10: An advance keeps the read or write direction of the burst's load. `wrN` (0 = write, 1 = read) is ignored during advances.
- R11: After reset no operation is pending and `dataDrive` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Active-low clock enable; high freezes the block |
| loadN | input | 1 | 0 = load new address, 1 = advance burst |
| wrN | input | 1 | Direction at load: 0 write, 1 read |
| csAN | input | 1 | Chip select, active low |
| csB | input | 1 | Chip select, active high |
| csCN | input | 1 | Chip select, active low |
| orderLinear | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address |
| laneWrN | input | LANES | Per-lane write enables, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dataIn | input | LANES*LANE_W | Write data, sampled at the end of the data phase |
| dataOut | output | LANES*LANE_W | Flow-through read data |
| dataDrive | output | 1 | High when the data pins drive; low means they float |

## Verification
The hardest case to reach is a burst whose advance cycles carry misleading inputs: a junk address, the opposite order bit and the opposite direction. The stimulus sets these up to expose any leak from the ports into a running burst. The stimulus first fills four words with a linear write burst whose advances hold `wrN` at read. It then reads them back as an interleaved burst whose advances hold `wrN` at write. Each word is distinct, so a wrong beat order or a changed direction shows up as a wrong word or a missing drive. Stalls are placed in the middle of both a read phase and a write phase, so that a frozen cycle is not mistaken for a committed one.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  // Strobes from the control pipeline to the datapath
  typedef struct packed {
    logic valid;   // a data phase is in progress
    logic write;   // direction of that phase
    logic linear;  // burst order latched at load
    logic commit;  // write lanes update at this edge
  } ctrlStrb_t;
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              loadN,
  input  logic              wrN,
  input  logic              csAN,
  input  logic              csB,
  input  logic              csCN,
  input  logic              orderLinear,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  laneWrN,
  output ctrlStrb_t         strb,
  output logic [ADDR_W-1:0] phAddr,
  output logic [LANES-1:0]  phLaneEn
);
  localparam int BEAT_W = 2;

  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beat;
  logic              opValid, opWrite, opLinear;
  logic              allSel;
  logic [BEAT_W-1:0] lowBits;

  assign allSel = ~csAN & csB & ~csCN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      beat     <= '0;
      opValid  <= 1'b0;
      opWrite  <= 1'b0;
      opLinear <= 1'b1;
      phLaneEn <= '0;
    end else if (!clkEnN) begin
      phLaneEn <= ~laneWrN;
      if (!loadN) begin
        baseAddr <= addr;
        beat     <= '0;
        opValid  <= allSel;
        opWrite  <= allSel & ~wrN;
        opLinear <= orderLinear;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  always_comb begin
    if (opLinear) lowBits = baseAddr[BEAT_W-1:0] + beat;
    else          lowBits = baseAddr[BEAT_W-1:0] ^ beat;
  end

  assign phAddr      = {baseAddr[ADDR_W-1:BEAT_W], lowBits};
  assign strb.valid  = opValid;
  assign strb.write  = opWrite;
  assign strb.linear = opLinear;
  assign strb.commit = opValid & opWrite & ~clkEnN;
endmodule

// File: rtl/zbt_datapath.sv
module zbt_datapath
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    outEnN,
  input  ctrlStrb_t               strb,
  input  logic [ADDR_W-1:0]       phAddr,
  input  logic [LANES-1:0]        phLaneEn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] wrMask;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign wrMask[g*LANE_W +: LANE_W] = {LANE_W{phLaneEn[g]}};
  end

  always_ff @(posedge clk) begin
    if (strb.commit)
      mem[phAddr] <= (mem[phAddr] & ~wrMask) | (dataIn & wrMask);
  end

  assign dataOut   = mem[phAddr];
  assign dataDrive = strb.valid & ~strb.write & ~outEnN;
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    loadN,
  input  logic                    wrN,
  input  logic                    csAN,
  input  logic                    csB,
  input  logic                    csCN,
  input  logic                    orderLinear,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        laneWrN,
  input  logic                    outEnN,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);
  ctrlStrb_t         strb;
  logic [ADDR_W-1:0] phAddr;
  logic [LANES-1:0]  phLaneEn;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN), .wrN(wrN),
    .csAN(csAN), .csB(csB), .csCN(csCN), .orderLinear(orderLinear),
    .addr(addr), .laneWrN(laneWrN), .strb(strb), .phAddr(phAddr),
    .phLaneEn(phLaneEn)
  );

  zbt_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .outEnN(outEnN), .strb(strb), .phAddr(phAddr),
    .phLaneEn(phLaneEn), .dataIn(dataIn), .dataOut(dataOut),
    .dataDrive(dataDrive)
  );
endmodule

// File: rtl/zbt_sram_checker.sv
module zbt_sram_checker
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              loadN,
  input logic              csAN,
  input logic              csB,
  input logic              csCN,
  input logic              outEnN,
  input ctrlStrb_t         strb,
  input logic [ADDR_W-1:0] phAddr,
  input logic              dataDrive
);
  p_float_oe_r3: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataDrive);

  p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> $stable(phAddr));

  p_hold_phase_r4: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(strb.valid) && $stable(strb.write)));

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !loadN && !(!csAN && csB && !csCN)) |=> !strb.valid);

  p_write_float_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.valid && strb.write) |-> !dataDrive);

  p_burst_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && loadN) |=> (phAddr[ADDR_W-1:2] == $past(phAddr[ADDR_W-1:2])));

  p_linear_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && loadN && strb.linear) |=>
      (phAddr[1:0] == 2'($past(phAddr[1:0]) + 2'd1)));

  p_interleave_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && loadN && !strb.linear) |=> (phAddr[0] != $past(phAddr[0])));

  p_inherit_dir_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && loadN) |=> $stable(strb.write));
endmodule

bind zbt_sram_core zbt_sram_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN), .csAN(csAN),
  .csB(csB), .csCN(csCN), .outEnN(outEnN), .strb(strb), .phAddr(phAddr),
  .dataDrive(dataDrive)
);

// File: tb/zbt_sram_core_tb.sv
module zbt_sram_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 36;

  localparam logic [DW-1:0] D0 = 36'hA11111111;
  localparam logic [DW-1:0] D1 = 36'hB22222222;
  localparam logic [DW-1:0] D2 = 36'h000000000;
  localparam logic [DW-1:0] W0 = 36'h101010101;
  localparam logic [DW-1:0] W1 = 36'h202020202;
  localparam logic [DW-1:0] W2 = 36'h303030303;
  localparam logic [DW-1:0] W3 = 36'h404040404;

  // ld = loadN, wr = wrN, sel = all chip selects active (else csB low),
  // din = dataIn this cycle, chk: 0 none, 1 expect word, 2 expect float
  typedef struct packed {
    logic          ld;
    logic          wr;
    logic          sel;
    logic          lin;
    logic [AW-1:0] a;
    logic [3:0]    ln;
    logic [DW-1:0] din;
    logic [1:0]    chk;
    logic [DW-1:0] exp;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b1,1'b1,6'h10,4'h0,36'h0,2'd0,36'h0,4'd0},  // write 0x10
    '{1'b0,1'b0,1'b1,1'b1,6'h11,4'h0,D0,2'd2,36'h0,4'd6},     // R6 write phase floats
    '{1'b0,1'b1,1'b1,1'b1,6'h10,4'h0,D1,2'd2,36'h0,4'd6},     // R6
    '{1'b0,1'b1,1'b1,1'b1,6'h11,4'h0,36'h0,2'd1,D0,4'd1},     // R1 write->read
    '{1'b0,1'b0,1'b1,1'b1,6'h12,4'h0,36'h0,2'd1,D1,4'd1},     // R1 read->write
    '{1'b0,1'b1,1'b1,1'b1,6'h12,4'h0,D2,2'd2,36'h0,4'd6},     // R6
    '{1'b0,1'b1,1'b0,1'b1,6'h00,4'h0,36'h0,2'd1,D2,4'd2},     // R2 read after write
    '{1'b0,1'b0,1'b1,1'b1,6'h12,4'hA,36'h0,2'd2,36'h0,4'd5},  // R5 deselect floats
    '{1'b0,1'b1,1'b1,1'b1,6'h12,4'h0,36'hFFFFFFFFF,2'd2,36'h0,4'd6},
    '{1'b0,1'b0,1'b1,1'b1,6'h20,4'h0,36'h0,2'd1,36'h007FC01FF,4'd9}, // R9 lanes 0,2
    '{1'b1,1'b1,1'b1,1'b0,6'h3F,4'h0,W0,2'd2,36'h0,4'd6},     // R10 wrN ignored
    '{1'b1,1'b1,1'b1,1'b0,6'h3F,4'h0,W1,2'd0,36'h0,4'd0},
    '{1'b1,1'b1,1'b1,1'b0,6'h3F,4'h0,W2,2'd0,36'h0,4'd0},
    '{1'b0,1'b1,1'b1,1'b0,6'h22,4'h0,W3,2'd0,36'h0,4'd0},     // interleaved read 0x22
    '{1'b1,1'b0,1'b1,1'b1,6'h00,4'h0,36'h0,2'd1,W2,4'd8},     // R8 beat0, R10
    '{1'b1,1'b0,1'b1,1'b1,6'h00,4'h0,36'h0,2'd1,W3,4'd8},     // R8 beat1 -> 3
    '{1'b1,1'b0,1'b1,1'b1,6'h00,4'h0,36'h0,2'd1,W0,4'd8},     // R8 beat2 -> 0
    '{1'b0,1'b1,1'b1,1'b1,6'h23,4'h0,36'h0,2'd1,W1,4'd8},     // R8 beat3 -> 1
    '{1'b1,1'b1,1'b1,1'b0,6'h00,4'h0,36'h0,2'd1,W3,4'd7},     // R7 beat0
    '{1'b1,1'b1,1'b1,1'b0,6'h00,4'h0,36'h0,2'd1,W0,4'd7},     // R7 wraps to 0
    '{1'b0,1'b1,1'b0,1'b1,6'h00,4'h0,36'h0,2'd1,W1,4'd7},     // R7
    '{1'b0,1'b1,1'b0,1'b1,6'h00,4'h0,36'h0,2'd2,36'h0,4'd5}   // R5
  };

  logic clk = 1'b0;
  logic rstN, clkEnN, loadN, wrN, csAN, csB, csCN, orderLinear, outEnN;
  logic [AW-1:0] addr;
  logic [3:0]    laneWrN;
  logic [DW-1:0] dataIn, dataOut;
  logic          dataDrive;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zbt_sram_core dut_i (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN), .wrN(wrN),
    .csAN(csAN), .csB(csB), .csCN(csCN), .orderLinear(orderLinear),
    .addr(addr), .laneWrN(laneWrN), .outEnN(outEnN), .dataIn(dataIn),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  task automatic checkWord(input string tag, input logic [DW-1:0] expW);
    checks++;
    if (!(dataDrive === 1'b1 && dataOut === expW)) begin
      failures++;
      $display("FAIL %s: drive=%b data=%h expected drive=1 data=%h",
               tag, dataDrive, dataOut, expW);
    end
  endtask

  task automatic checkFloat(input string tag);
    checks++;
    if (dataDrive !== 1'b0) begin
      failures++;
      $display("FAIL %s: drive=%b expected drive=0", tag, dataDrive);
    end
  endtask

  task automatic cmd(input logic ld, input logic wr, input logic [AW-1:0] a);
    loadN = ld; wrN = wr; addr = a; csAN = 1'b0; csB = 1'b1; csCN = 1'b0;
    orderLinear = 1'b1; laneWrN = 4'h0;
  endtask

  task automatic idle();
    loadN = 1'b0; wrN = 1'b1; csAN = 1'b0; csB = 1'b0; csCN = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    rstN = 1'b0; clkEnN = 1'b0; outEnN = 1'b0; dataIn = '0;
    addr = '0; laneWrN = 4'h0; orderLinear = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    checkFloat("R11 in reset");
    rstN = 1'b1;
    @(negedge clk);
    #1 checkFloat("R11 after reset");

    for (int i = 0; i < NV; i++) begin
      dataIn = VECS[i].din;
      #1;
      if (VECS[i].chk == 2'd1) checkWord($sformatf("R%0d vec %0d", VECS[i].rq, i), VECS[i].exp);
      else if (VECS[i].chk == 2'd2) checkFloat($sformatf("R%0d vec %0d", VECS[i].rq, i));
      loadN = VECS[i].ld; wrN = VECS[i].wr; csAN = 1'b0; csB = VECS[i].sel;
      csCN = 1'b0; orderLinear = VECS[i].lin; addr = VECS[i].a;
      laneWrN = VECS[i].ln;
      @(negedge clk);
    end

    // R3: output enable acts without a clock edge
    cmd(1'b0, 1'b1, 6'h10);
    @(negedge clk);
    #1 checkWord("R3 before", D0);
    outEnN = 1'b1;
    #1 checkFloat("R3 disabled");
    outEnN = 1'b0;
    #1 checkWord("R3 restored", D0);
    idle();

    // R4: stall during a read phase
    @(negedge clk);
    cmd(1'b0, 1'b1, 6'h11);
    @(negedge clk);
    #1 checkWord("R4 read", D1);
    clkEnN = 1'b1;
    cmd(1'b0, 1'b1, 6'h10);
    @(negedge clk);
    #1 checkWord("R4 held", D1);
    clkEnN = 1'b0;
    @(negedge clk);
    #1 checkWord("R4 resumed", D0);
    idle();

    // R4: stall during a write phase
    @(negedge clk);
    cmd(1'b0, 1'b0, 6'h30);
    @(negedge clk);
    dataIn = 36'h555555555;
    clkEnN = 1'b1;
    cmd(1'b0, 1'b1, 6'h30);
    @(negedge clk);
    dataIn = 36'h9ABCDEF01;
    clkEnN = 1'b0;
    @(negedge clk);
    #1 checkWord("R4 stalled write", 36'h9ABCDEF01);
    idle();

    // R5: partial chip select blocks writes
    @(negedge clk);
    cmd(1'b0, 1'b0, 6'h10);
    csAN = 1'b1;
    @(negedge clk);
    dataIn = 36'h0DEADBEEF;
    #1 checkFloat("R5 csAN high");
    cmd(1'b0, 1'b0, 6'h10);
    csCN = 1'b1;
    @(negedge clk);
    #1 checkFloat("R5 csCN high");
    cmd(1'b0, 1'b1, 6'h10);
    @(negedge clk);
    #1 checkWord("R5 no write", D0);
    idle();
    @(negedge clk);
    finishRun();
  end
endmodule